// File: doc/BRIEF.md
# Dual-Channel Interrupt Mask Latch

This block sits on the register bus of a two-channel disk interface card. It keeps one interrupt enable flag for each drive channel, and it merges the drive interrupt lines into a single host interrupt request. Software controls a flag through that channel's mask address. Any write strobe to the address turns the channel on. A read strobe to the same address turns it off.

Each channel also has a status address. A read there returns the channel's raw drive interrupt line in bit 0, whether or not the channel is enabled. Driver code normally routes one channel at a time: it writes the wanted channel's mask address and reads the other channel's mask address, so that only one channel is ever enabled. The bus carries no write data, because the value written has no meaning here. Read data and the host request are both registered outputs.

Top module: `dual_irq_gate`

## Requirements
- R1: After a synchronous reset, both enables are clear, `host_irq` is 0 and `rdata` is 0.
- R2: A write strobe to a channel's mask address sets that channel's enable at the same clock edge. The mask address of channel 0 is 0x2200 and that of channel 1 is 0x3200.
- R3: A read strobe to a channel's mask address clears that channel's enable. The read returns the enable value from before the read in bit 0, and all other bits are 0.
- R4: A read strobe to a channel's status address returns that channel's raw drive interrupt line in bit 0, and all other bits are 0. The line is reported even when the channel is disabled. The status address of channel 0 is 0x2290 and that of channel 1 is 0x3290.
- R5: At each clock edge, `host_irq` is loaded with the OR over all channels of (enable AND drive line), using the enables and lines present before that edge.
- R6: An access to one channel's addresses leaves the other channel's enable unchanged. A write to mask 1 paired with a read of mask 0 leaves only channel 1 enabled.
- R7: A read strobe to any unmapped address returns 0 and changes no enable. A write strobe to an unmapped address changes no enable.
- R8: When a read strobe and a write strobe reach the same mask address in the same cycle, the enable ends up set.
- R9: `rdata` changes only on a cycle with a read strobe, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| drv_irq | input | N_CH | Raw interrupt line of each drive channel |
| rdata | output | DATA_W | Registered read data |
| host_irq | output | 1 | Registered combined interrupt request |

## Verification
The bench drives directed cases first. These cover a drive interrupt arriving on the disabled channel only, which tells gating apart from plain OR-ing of the lines. They also cover the write-one/read-other routing pair, which shows whether the two channels' decoding is independent. Further cases cover status reads of a masked channel, which separate the raw status path from the gated one, and a read and a write strobe landing together on one mask address. After that comes a long seeded random run. It mixes writes, reads and combined strobes over all mapped addresses and a set of near-miss unmapped addresses, with the drive lines changing at random. This run exposes wrong address compares, lost enables and a wrong one-cycle alignment of the host request.

// File: rtl/irqgate_pkg.sv
package irqgate_pkg;
  localparam int unsigned CH_BASE   = 32'h2000;
  localparam int unsigned CH_STRIDE = 32'h1000;
  localparam int unsigned MASK_OFS  = 32'h0200;
  localparam int unsigned STAT_OFS  = 32'h0290;

  function automatic int unsigned mask_addr(input int unsigned ch);
    return CH_BASE + ch * CH_STRIDE + MASK_OFS;
  endfunction

  function automatic int unsigned stat_addr(input int unsigned ch);
    return CH_BASE + ch * CH_STRIDE + STAT_OFS;
  endfunction
endpackage

// File: rtl/irqgate_decode.sv
module irqgate_decode
  import irqgate_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CH-1:0]   mask_hit,
  output logic [N_CH-1:0]   stat_hit
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] MADDR = ADDR_W'(mask_addr(c));
    localparam logic [ADDR_W-1:0] SADDR = ADDR_W'(stat_addr(c));
    assign mask_hit[c] = (addr == MADDR);
    assign stat_hit[c] = (addr == SADDR);
  end
endmodule

// File: rtl/irqgate_enable.sv
module irqgate_enable (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  always_ff @(posedge clk) begin
    if (rst)        en_o <= 1'b0;
    else if (set_i) en_o <= 1'b1;
    else if (clr_i) en_o <= 1'b0;
  end

  p_set_on_write_r2: assert property (@(posedge clk) disable iff (rst)
    set_i |=> en_o);
  p_clear_on_read_r3: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !en_o);
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && set_i) |=> en_o);
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(en_o));
endmodule

// File: rtl/irqgate_readmux.sv
module irqgate_readmux #(
  parameter int N_CH   = 2,
  parameter int DATA_W = 8
) (
  input  logic [N_CH-1:0]   mask_hit,
  input  logic [N_CH-1:0]   stat_hit,
  input  logic [N_CH-1:0]   en,
  input  logic [N_CH-1:0]   drv_irq,
  output logic [DATA_W-1:0] rd_next
);
  logic bit0;
  always_comb begin
    bit0 = 1'b0;
    for (int c = 0; c < N_CH; c++) begin
      if (mask_hit[c]) bit0 = bit0 | en[c];
      if (stat_hit[c]) bit0 = bit0 | drv_irq[c];
    end
    rd_next = {{(DATA_W-1){1'b0}}, bit0};
  end
endmodule

// File: rtl/dual_irq_gate.sv
module dual_irq_gate #(
  parameter int N_CH   = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [N_CH-1:0]   drv_irq,
  output logic [DATA_W-1:0] rdata,
  output logic              host_irq
);
  logic [N_CH-1:0]   mask_hit, stat_hit, en;
  logic [DATA_W-1:0] rd_next;

  irqgate_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .mask_hit(mask_hit), .stat_hit(stat_hit)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_en
    irqgate_enable u_en (
      .clk(clk), .rst(rst),
      .set_i(bus_wr & mask_hit[c]),
      .clr_i(bus_rd & mask_hit[c]),
      .en_o(en[c])
    );
  end

  irqgate_readmux #(.N_CH(N_CH), .DATA_W(DATA_W)) u_rdmux (
    .mask_hit(mask_hit), .stat_hit(stat_hit), .en(en),
    .drv_irq(drv_irq), .rd_next(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      host_irq <= 1'b0;
    end else begin
      if (bus_rd) rdata <= rd_next;
      host_irq <= |(en & drv_irq);
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (host_irq == 1'b0 && en == '0 && rdata == '0));
  p_quiet_when_gated_r5: assert property (@(posedge clk) disable iff (rst)
    ((en & drv_irq) == '0) |=> !host_irq);
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata));
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && mask_hit == '0 && stat_hit == '0) |=> (rdata == '0));
  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    p_status_raw_r4: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && stat_hit[c]) |=> (rdata[0] == $past(drv_irq[c])));
  end
endmodule

// File: tb/dual_irq_gate_bench.sv
module dual_irq_gate_bench;
  localparam int N_CH = 2, ADDR_W = 16, DATA_W = 8;
  localparam logic [15:0] M0 = 16'h2200, M1 = 16'h3200, S0 = 16'h2290, S1 = 16'h3290;

  logic clk = 0, rst = 1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [N_CH-1:0] drv_irq = '0;
  logic [DATA_W-1:0] rdata;
  logic host_irq;

  int n_chk = 0, n_fail = 0;
  logic [1:0] exp_en = 2'b00;
  logic [DATA_W-1:0] exp_rd = '0;

  always #5 clk = ~clk;

  dual_irq_gate #(.N_CH(N_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dual_irq_gate (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .drv_irq(drv_irq), .rdata(rdata), .host_irq(host_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] model_rd(input logic [15:0] a, input logic [1:0] en,
                                                 input logic [1:0] irq);
    if (a == M0) return DATA_W'(en[0]);
    if (a == M1) return DATA_W'(en[1]);
    if (a == S0) return DATA_W'(irq[0]);
    if (a == S1) return DATA_W'(irq[1]);
    return '0;
  endfunction

  function automatic logic [1:0] model_en(input logic [15:0] a, input logic wr, input logic rd,
                                          input logic [1:0] en);
    logic [1:0] n = en;
    if (a == M0) n[0] = wr ? 1'b1 : (rd ? 1'b0 : en[0]);
    if (a == M1) n[1] = wr ? 1'b1 : (rd ? 1'b0 : en[1]);
    return n;
  endfunction

  // one access plus one idle cycle, then host_irq and rdata are checked
  task automatic access(input logic wr, input logic rd, input logic [15:0] a,
                        input logic [1:0] irq, input string req);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; drv_irq = irq;
    if (rd) exp_rd = model_rd(a, exp_en, irq);
    exp_en = model_en(a, wr, rd, exp_en);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    @(negedge clk);
    chk({req, " host_irq"}, host_irq, |(exp_en & irq));
    chk({req, " rdata"}, rdata, exp_rd);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] addrs [8];
    int seed;
    addrs = '{M0, M1, S0, S1, 16'h2201, 16'h3290 ^ 16'h1000 ^ 16'h0001, 16'h0004, 16'h1200};
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    drv_irq = 2'b11;
    @(negedge clk);
    chk("R1 host_irq", host_irq, 0);
    chk("R1 rdata", rdata, 0);
    rst = 0;
    // R1: enables clear after reset, so lines active give no request
    access(0, 0, 16'h0000, 2'b11, "R1 idle");
    // R2: channel 0 enable, line 0 active
    access(1, 0, M0, 2'b01, "R2 set ch0");
    // R5: only disabled channel's line active
    access(0, 0, 16'h0000, 2'b10, "R5 gated ch1");
    // R4: status of disabled channel shows raw line
    access(0, 1, S1, 2'b10, "R4 status ch1 masked");
    access(0, 1, S0, 2'b10, "R4 status ch0 low");
    // R6: route to ch1: write mask1, read mask0
    access(1, 0, M1, 2'b11, "R6 write mask1");
    access(0, 1, M0, 2'b11, "R6 read mask0 R3");
    chk("R6 enables", int'(exp_en), 2'b10);
    access(0, 0, 16'h0000, 2'b01, "R6 ch0 stays off");
    // R3: read of mask1 returns 1 and clears
    access(0, 1, M1, 2'b10, "R3 read mask1");
    access(0, 1, M1, 2'b10, "R3 read mask1 again");
    // R8: both strobes on one mask address
    access(1, 1, M0, 2'b01, "R8 set wins");
    // R7: unmapped accesses
    access(1, 1, 16'h2201, 2'b11, "R7 unmapped");
    access(0, 1, 16'h0004, 2'b11, "R7 unmapped read");
    // R9: write leaves read data unchanged
    access(1, 0, M1, 2'b11, "R9 hold");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 4));
      access(op == 0 || op == 3, op == 1 || op == 2 || op == 3, addrs[$urandom_range(0, 7)],
             2'($urandom), "R2 R3 R4 R5 R7 R9 random");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule